// File: doc/BRIEF.md
# Local Bus Access Timeout

This block watches accesses on a local peripheral bus and flags any access that has run too long. When an access begins, the block starts a fresh measurement. A prescaler divides the system clock down to one tick per microsecond, and a counter counts those ticks. If the slave does not terminate the access before the chosen limit, the block raises a one-cycle transfer-error acknowledge. It also sets a status flag that stays set until software clears it.

Software selects the limit with a two-bit code. Three codes give finite periods and one code disables the timeout. Software also controls a master enable. Accesses that are routed onward to the VMEbus are not timed here, because another timer covers them. The period code and the VMEbus routing are captured when an access starts, so changing the code in the middle of an access affects only the next access.

Top module: `lbusTimeout`

## Requirements
- R1: After reset, teaPulse and timeoutFlag are both 0.
- R2: With periodSel 00, 01 or 10 the limit is PER_A, PER_B or PER_C microseconds (defaults 8, 64, 256). One microsecond is CLKS_PER_US clock cycles. Let E0 be the rising edge that first samples accessActive high. Then teaPulse is high in the cycle that follows edge E0 + limit x CLKS_PER_US.
- R3: With periodSel 11 at access start, no teaPulse is produced however long the access lasts.
- R4: teaPulse is high for exactly one cycle, and at most once per access, even if accessActive stays high after the timeout.
- R5: A normalAck sampled high at any edge up to and including the expiry edge ends the timing of that access. No teaPulse follows and timeoutFlag is not set.
- R6: If vmeBound is high at the edge that starts an access, that access is not timed and produces no teaPulse.
- R7: The counter and prescaler advance only on edges where timerEn is high. With timerEn low for the whole access, no teaPulse occurs.
- R8: The tick counter and the prescaler restart from zero at every access start, so no partial count carries over from an earlier access.
- R9: periodSel is captured at access start. A change during the access takes effect only at the next access.
- R10: timeoutFlag is set in the same cycle as teaPulse. It stays set across later accesses until a clearStatus strobe is sampled. If the clear and a timeout fall on the same edge, the flag is left set.
- R11: When accessActive falls, the timing of that access stops, and a low gap of at least one cycle separates accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerEn | input | 1 | Software enable for the timeout counter |
| periodSel | input | 2 | Limit code: 00, 01, 10 finite periods; 11 no timeout |
| accessActive | input | 1 | High while a local-bus access is in progress |
| vmeBound | input | 1 | Access is routed onward to the VMEbus (not timed here) |
| normalAck | input | 1 | Normal termination of the access by the slave |
| clearStatus | input | 1 | Write-one-to-clear strobe for timeoutFlag |
| teaPulse | output | 1 | One-cycle transfer-error acknowledge on timeout |
| timeoutFlag | output | 1 | Sticky timeout status |

## Verification
The bench measures, for each finite code, the exact cycle in which the error pulse appears. A prescaler or counter that is off by one moves the pulse a cycle early or late, and that miscompare is caught. One test places the normal acknowledge on the expiry edge itself; a design that gives priority to the timeout would pulse and set the flag there. Other tests cover:
- a short access followed by a full one, which exposes a counter that is not cleared at access start;
- a code change in mid-access, which exposes a design that uses the live code;
- a clear strobe on the expiry edge, which checks that the set wins;
- the VMEbus-routed, disabled and infinite cases, each of which must stay silent for far longer than the longest period.

// File: rtl/lbusTimeoutPkg.sv
package lbusTimeoutPkg;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_INF = 2'b11
  } periodSel_e;

  typedef struct packed {
    logic clrAll;
    logic loadSel;
    logic countEn;
  } tmrStrobe_t;

endpackage

// File: rtl/lbusTimeoutDp.sv
module lbusTimeoutDp
  import lbusTimeoutPkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int PER_A = 8,
  parameter int PER_B = 64,
  parameter int PER_C = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strb,
  input  logic [1:0] periodSel,
  output logic       atLimit
);

  localparam int MAX_AB = (PER_A > PER_B) ? PER_A : PER_B;
  localparam int MAXP   = (MAX_AB > PER_C) ? MAX_AB : PER_C;
  localparam int CNT_W  = $clog2(MAXP + 1);
  localparam int PRE_W  = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] usCnt;
  logic [CNT_W-1:0] limitM1;
  periodSel_e       selReg;
  logic             usTick;

  always_comb begin
    case (selReg)
      SEL_A:   limitM1 = CNT_W'(PER_A - 1);
      SEL_B:   limitM1 = CNT_W'(PER_B - 1);
      SEL_C:   limitM1 = CNT_W'(PER_C - 1);
      default: limitM1 = '1;
    endcase
  end

  assign usTick  = (preCnt == PRE_LAST);
  assign atLimit = usTick && (usCnt == limitM1) && (selReg != SEL_INF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      usCnt  <= '0;
      selReg <= SEL_A;
    end else if (strb.clrAll) begin
      preCnt <= '0;
      usCnt  <= '0;
      if (strb.loadSel) selReg <= periodSel_e'(periodSel);
    end else if (strb.countEn) begin
      if (usTick) begin
        preCnt <= '0;
        usCnt  <= usCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  p_pre_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    int'(preCnt) < CLKS_PER_US);

  p_clr_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (usCnt == '0 && preCnt == '0));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadSel |=> $stable(selReg));

endmodule

// File: rtl/lbusTimeoutCtl.sv
module lbusTimeoutCtl
  import lbusTimeoutPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       timerEn,
  input  logic [1:0] periodSel,
  input  logic       accessActive,
  input  logic       vmeBound,
  input  logic       normalAck,
  input  logic       clearStatus,
  input  logic       atLimit,
  output tmrStrobe_t strb,
  output logic       teaPulse,
  output logic       timeoutFlag
);

  logic prevActive;
  logic running;
  logic startAcc;
  logic expire;

  assign startAcc     = accessActive && !prevActive;
  assign strb.clrAll  = startAcc;
  assign strb.loadSel = startAcc;
  assign strb.countEn = running && timerEn && accessActive && !normalAck;
  assign expire       = strb.countEn && atLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevActive  <= 1'b0;
      running     <= 1'b0;
      teaPulse    <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      prevActive <= accessActive;
      teaPulse   <= expire;
      if (startAcc)
        running <= !vmeBound && (periodSel != SEL_INF);
      else if (!accessActive || normalAck || expire)
        running <= 1'b0;
      if (expire)
        timeoutFlag <= 1'b1;
      else if (clearStatus)
        timeoutFlag <= 1'b0;
    end
  end

  p_tea_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    teaPulse |=> !teaPulse);

  p_tea_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    teaPulse |-> timeoutFlag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !clearStatus) |=> timeoutFlag);

  p_ack_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    normalAck |=> !teaPulse);

  p_vme_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && vmeBound) |=> !running);

  p_inf_skip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && periodSel == SEL_INF) |=> !running);

  p_en_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |=> !teaPulse);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !accessActive |=> !teaPulse);

endmodule

// File: rtl/lbusTimeout.sv
module lbusTimeout
  import lbusTimeoutPkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int PER_A = 8,
  parameter int PER_B = 64,
  parameter int PER_C = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       timerEn,
  input  logic [1:0] periodSel,
  input  logic       accessActive,
  input  logic       vmeBound,
  input  logic       normalAck,
  input  logic       clearStatus,
  output logic       teaPulse,
  output logic       timeoutFlag
);

  tmrStrobe_t strb;
  logic       atLimit;

  lbusTimeoutCtl uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .timerEn      (timerEn),
    .periodSel    (periodSel),
    .accessActive (accessActive),
    .vmeBound     (vmeBound),
    .normalAck    (normalAck),
    .clearStatus  (clearStatus),
    .atLimit      (atLimit),
    .strb         (strb),
    .teaPulse     (teaPulse),
    .timeoutFlag  (timeoutFlag)
  );

  lbusTimeoutDp #(
    .CLKS_PER_US (CLKS_PER_US),
    .PER_A       (PER_A),
    .PER_B       (PER_B),
    .PER_C       (PER_C)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .periodSel (periodSel),
    .atLimit   (atLimit)
  );

endmodule

// File: tb/sim_lbusTimeout.sv
`timescale 1ns/1ps
module sim_lbusTimeout;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       timerEn = 1'b0;
  logic [1:0] periodSel = 2'b00;
  logic       accessActive = 1'b0;
  logic       vmeBound = 1'b0;
  logic       normalAck = 1'b0;
  logic       clearStatus = 1'b0;
  logic       teaPulse;
  logic       timeoutFlag;

  int vectors = 0;
  int misses = 0;

  always #5 clk = ~clk;

  lbusTimeout #(.CLKS_PER_US(DIV)) u0 (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .periodSel(periodSel),
    .accessActive(accessActive), .vmeBound(vmeBound), .normalAck(normalAck),
    .clearStatus(clearStatus), .teaPulse(teaPulse), .timeoutFlag(timeoutFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One access. Sample index i counts negedges after the one that raised
  // accessActive; a pulse after edge E0+N is seen at index N+1.
  task automatic runAccess(input logic [1:0] sel, input logic vme, input logic en,
                           input int hold, input int ackAt, input int chgAt,
                           input logic [1:0] chgSel, input int clrAt,
                           output int firstTea, output int teaCnt);
    @(negedge clk);
    periodSel = sel; vmeBound = vme; timerEn = en; accessActive = 1'b1;
    firstTea = 0; teaCnt = 0;
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (teaPulse) begin
        teaCnt++;
        if (firstTea == 0) firstTea = i;
      end
      clearStatus = (i == clrAt);
      if (i == chgAt) periodSel = chgSel;
      if (i == ackAt) normalAck = 1'b1;
      if (ackAt > 0 && i == ackAt + 1) begin
        normalAck = 1'b0;
        accessActive = 1'b0;
      end
    end
    accessActive = 1'b0; normalAck = 1'b0; clearStatus = 1'b0;
    @(negedge clk);
    if (teaPulse) teaCnt++;
  endtask

  task automatic clearFlag();
    @(negedge clk); clearStatus = 1'b1;
    @(negedge clk); clearStatus = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 tea after reset", int'(teaPulse), 0);
    chk("R1 flag after reset", int'(timeoutFlag), 0);
  endtask

  task automatic testPeriods();
    int f, c;
    runAccess(2'b00, 1'b0, 1'b1, 40, 0, 0, 2'b00, 0, f, c);
    chk("R2 code00 pulse cycle", f, 8 * DIV + 1);
    chk("R4 code00 pulse count", c, 1);
    chk("R10 flag set by timeout", int'(timeoutFlag), 1);
    clearFlag();
    chk("R10 flag cleared", int'(timeoutFlag), 0);
    runAccess(2'b01, 1'b0, 1'b1, 64 * DIV + 20, 0, 0, 2'b00, 0, f, c);
    chk("R2 code01 pulse cycle", f, 64 * DIV + 1);
    chk("R4 code01 pulse count", c, 1);
    runAccess(2'b10, 1'b0, 1'b1, 256 * DIV + 20, 0, 0, 2'b00, 0, f, c);
    chk("R2 code10 pulse cycle", f, 256 * DIV + 1);
    chk("R4 code10 pulse count", c, 1);
    clearFlag();
  endtask

  task automatic testInfinite();
    int f, c;
    runAccess(2'b11, 1'b0, 1'b1, 256 * DIV + 100, 0, 0, 2'b00, 0, f, c);
    chk("R3 infinite no pulse", c, 0);
    chk("R3 infinite flag clear", int'(timeoutFlag), 0);
  endtask

  task automatic testAck();
    int f, c;
    runAccess(2'b00, 1'b0, 1'b1, 60, 8 * DIV, 0, 2'b00, 0, f, c);
    chk("R5 ack on expiry edge no pulse", c, 0);
    chk("R5 ack on expiry edge flag", int'(timeoutFlag), 0);
    runAccess(2'b00, 1'b0, 1'b1, 60, 5, 0, 2'b00, 0, f, c);
    chk("R5 early ack no pulse", c, 0);
  endtask

  task automatic testVme();
    int f, c;
    runAccess(2'b00, 1'b1, 1'b1, 100, 0, 0, 2'b00, 0, f, c);
    chk("R6 vme bound no pulse", c, 0);
    chk("R6 vme bound flag", int'(timeoutFlag), 0);
  endtask

  task automatic testEnable();
    int f, c;
    runAccess(2'b00, 1'b0, 1'b0, 100, 0, 0, 2'b00, 0, f, c);
    chk("R7 disabled no pulse", c, 0);
  endtask

  task automatic testRestart();
    int f, c;
    runAccess(2'b00, 1'b0, 1'b1, 20, 0, 0, 2'b00, 0, f, c);
    chk("R11 dropped access no pulse", c, 0);
    runAccess(2'b00, 1'b0, 1'b1, 40, 0, 0, 2'b00, 0, f, c);
    chk("R8 count restarts at access start", f, 8 * DIV + 1);
    clearFlag();
  endtask

  task automatic testMidChange();
    int f, c;
    runAccess(2'b00, 1'b0, 1'b1, 40, 0, 2, 2'b10, 0, f, c);
    chk("R9 mid-access change ignored", f, 8 * DIV + 1);
    runAccess(2'b10, 1'b0, 1'b1, 256 * DIV + 10, 0, 0, 2'b00, 0, f, c);
    chk("R9 new code on next access", f, 256 * DIV + 1);
    clearFlag();
  endtask

  task automatic testSticky();
    int f, c;
    // clearStatus sampled on the expiry edge: the set must win
    runAccess(2'b00, 1'b0, 1'b1, 40, 0, 0, 2'b00, 8 * DIV, f, c);
    chk("R10 set wins over clear", int'(timeoutFlag), 1);
    runAccess(2'b00, 1'b0, 1'b0, 30, 0, 0, 2'b00, 0, f, c);
    chk("R10 flag sticky across access", int'(timeoutFlag), 1);
    clearFlag();
    chk("R10 flag cleared by strobe", int'(timeoutFlag), 0);
  endtask

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPeriods();
    testInfinite();
    testAck();
    testVme();
    testEnable();
    testRestart();
    testMidChange();
    testSticky();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule